// File: doc/BRIEF.md
# Auxiliary-Register Data Address Generator

This block forms the data-memory address for each access of a 16-bit accumulator-style signal processor. It keeps a bank of six 16-bit address registers. An instruction names the register it wants in a 3-bit field of its own, so no separate pointer register has to be set first. An access uses one of two modes. In direct mode the address is the 12-bit address field of the instruction. In indirect mode the address is the named register, which can then be left alone, stepped up by one or stepped down by one at the end of the same cycle.

The registers have two load paths. A dedicated write path loads a register with a value. A register can also be loaded with the word that the current access returns, so one register can be filled from a location that another register points at. The highest addresses of the 16-bit data space form a window of memory-mapped ports. An access that lands in this window is routed to a port and never reaches the RAM. Reads return the word of an input port in the same cycle. Writes latch the word into an output port and raise a strobe for one cycle. The RAM array, the ALU and the instruction decoder lie outside this block. The RAM is read asynchronously: its data comes back in the cycle that presents the address.

Top module: `agu_top`

## Requirements
- R1: After reset all address registers hold 0, every output port holds 0, and no port strobe or input-port select is asserted.
- R2: A valid direct access (`acc_indirect`=0) drives `ram_addr` with `acc_dir` zero-extended to 16 bits and leaves every address register unchanged.
- R3: A valid indirect access drives `ram_addr` with the register named by `acc_sel` (values 0 to 5). Select values 6 and 7 name no register: they give address 0 and update nothing.
- R4: `acc_mod` chooses the post-modification of an indirect access: 2'b01 adds one, 2'b10 subtracts one, and 2'b00 or 2'b11 leaves the register unchanged. The arithmetic wraps modulo 2^16. The new value is written at the clock edge that ends the access.
- R5: When `ar_wr_en` is 1, the register named by `ar_wr_sel` takes `ar_wr_data` at the clock edge, and the next access sees the new value.
- R6: A valid access with `ar_ld_en`=1 loads the register named by `ar_ld_sel` with the `rd_data` of that access. The address may come from a different register.
- R7: When several updates target the same register in one cycle, the write path wins over the memory load, and the memory load wins over post-modification.
- R8: The port window is the top NPORT = max(input count, output count) addresses. Address 0xFFFF-k is port k. An access inside the window asserts neither `ram_rd` nor `ram_wr`.
- R9: A valid read of window address 0xFFFF-k, where k is below the input count, sets only bit k of `port_in_sel` and returns input port k on `rd_data` in the same cycle. A window address with no input port behind it returns 0 and sets no select bit.
- R10: A valid write of window address 0xFFFF-k, where k is below the output count, loads `wr_data` into output port k. In the next cycle the port shows that word and bit k of `port_out_stb` is high for exactly one cycle. The port keeps the word after the strobe falls.
- R11: Outside the window, `ram_rd` and `ram_wr` follow `acc_rd` and `acc_wr` during a valid access, and `rd_data` equals `ram_rdata`.
- R12: While `acc_valid` is 0, there is no RAM strobe, no port select, no port strobe, no post-modification and no memory load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A data access occurs in this cycle |
| acc_indirect | input | 1 | 1 = address from a register, 0 = direct field |
| acc_dir | input | 12 | Direct address field |
| acc_sel | input | 3 | Register named by the instruction |
| acc_mod | input | 2 | Post-modification code |
| acc_rd | input | 1 | The access reads |
| acc_wr | input | 1 | The access writes |
| wr_data | input | 16 | Store data |
| ar_wr_en | input | 1 | Register write-path enable |
| ar_wr_sel | input | 3 | Register written by the write path |
| ar_wr_data | input | 16 | Value for the write path |
| ar_ld_en | input | 1 | Load a register from this access's read data |
| ar_ld_sel | input | 3 | Register loaded from read data |
| ram_rdata | input | 16 | Asynchronous RAM read data |
| port_in | input | 16*N_IN | Input port words, port k at bits [16k+15:16k] |
| ram_addr | output | 16 | Data address |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| ram_wdata | output | 16 | RAM write data |
| rd_data | output | 16 | Read word returned to the datapath |
| port_in_sel | output | N_IN | One-hot select of the input port being read |
| port_out | output | 16*N_OUT | Output port words |
| port_out_stb | output | N_OUT | One-cycle strobe per output port after a write |

## Verification
The bench builds the block with two input ports and three output ports, so the window spans three addresses. This reaches a window address with no input port behind it (0xFFFD) and an output port at an index other than zero. The register count stays at six with a 3-bit select field, which leaves two select values that name no register. Decrementing from 0 wraps the address into the window, so the wrap and the port decode are exercised together.

// File: rtl/agu_pkg.sv
package agu_pkg;
   typedef enum logic [1:0] {
      PM_HOLD  = 2'b00,
      PM_INC   = 2'b01,
      PM_DEC   = 2'b10,
      PM_HOLD2 = 2'b11
   } postmod_e;
endpackage

// File: rtl/agu_regbank.sv
module agu_regbank #(
   parameter int DW     = 16,
   parameter int NUM_AR = 6,
   parameter int SEL_W  = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 upd_en,
   input  logic [SEL_W-1:0]     upd_sel,
   input  logic [DW-1:0]        upd_val,
   input  logic                 ld_en,
   input  logic [SEL_W-1:0]     ld_sel,
   input  logic [DW-1:0]        ld_val,
   input  logic                 wr_en,
   input  logic [SEL_W-1:0]     wr_sel,
   input  logic [DW-1:0]        wr_val,
   output logic [NUM_AR*DW-1:0] ar_flat
);
   for (genvar i = 0; i < NUM_AR; i++) begin : g_ar
      localparam logic [SEL_W-1:0] MY_ID = SEL_W'(i);
      logic [DW-1:0] r_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            r_q <= '0;
         else if (wr_en && wr_sel == MY_ID)
            r_q <= wr_val;
         else if (ld_en && ld_sel == MY_ID)
            r_q <= ld_val;
         else if (upd_en && upd_sel == MY_ID)
            r_q <= upd_val;
      end
      assign ar_flat[i*DW +: DW] = r_q;
   end
endmodule

// File: rtl/agu_addr_form.sv
module agu_addr_form
   import agu_pkg::*;
#(
   parameter int DW     = 16,
   parameter int NUM_AR = 6,
   parameter int SEL_W  = 3,
   parameter int DIR_W  = 12
) (
   input  logic [NUM_AR*DW-1:0] ar_flat,
   input  logic                 indirect,
   input  logic [SEL_W-1:0]     sel,
   input  logic [DIR_W-1:0]     dir,
   input  logic [1:0]           mod,
   output logic [DW-1:0]        eff_addr,
   output logic                 upd_req,
   output logic [DW-1:0]        upd_val
);
   logic [DW-1:0] cur;
   logic          sel_ok;
   postmod_e      pm;

   always_comb begin
      cur    = '0;
      sel_ok = 1'b0;
      for (int i = 0; i < NUM_AR; i++) begin
         if (sel == SEL_W'(i)) begin
            cur    = ar_flat[i*DW +: DW];
            sel_ok = 1'b1;
         end
      end
   end

   assign pm       = postmod_e'(mod);
   assign eff_addr = indirect ? cur : DW'(dir);

   always_comb begin
      unique case (pm)
         PM_INC:  upd_val = cur + DW'(1);
         PM_DEC:  upd_val = cur - DW'(1);
         default: upd_val = cur;
      endcase
   end

   assign upd_req = indirect && sel_ok && (pm == PM_INC || pm == PM_DEC);
endmodule

// File: rtl/agu_io_window.sv
module agu_io_window #(
   parameter int DW    = 16,
   parameter int N_IN  = 1,
   parameter int N_OUT = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_valid,
   input  logic                acc_rd,
   input  logic                acc_wr,
   input  logic [DW-1:0]       addr,
   input  logic [DW-1:0]       wr_data,
   input  logic [DW-1:0]       ram_rdata,
   input  logic [N_IN*DW-1:0]  port_in,
   output logic                ram_rd,
   output logic                ram_wr,
   output logic [DW-1:0]       rd_data,
   output logic [N_IN-1:0]     port_in_sel,
   output logic [N_OUT*DW-1:0] port_out,
   output logic [N_OUT-1:0]    port_out_stb
);
   localparam int NPORT = (N_IN > N_OUT) ? N_IN : N_OUT;
   localparam int IW    = (NPORT > 1) ? $clog2(NPORT) : 1;
   localparam logic [DW-1:0] WIN_BASE = ~DW'(NPORT - 1);

   logic          in_win;
   logic [IW-1:0] idx;
   logic [DW-1:0] addr_inv;

   assign in_win   = (addr >= WIN_BASE);
   assign addr_inv = ~addr;

   if (NPORT == 1) begin : g_idx_single
      assign idx = '0;
   end else begin : g_idx_multi
      assign idx = addr_inv[IW-1:0];
   end

   assign ram_rd = acc_valid && acc_rd && !in_win;
   assign ram_wr = acc_valid && acc_wr && !in_win;

   for (genvar k = 0; k < N_IN; k++) begin : g_in
      assign port_in_sel[k] = acc_valid && acc_rd && in_win && (idx == IW'(k));
   end

   always_comb begin
      rd_data = '0;
      if (!in_win) begin
         rd_data = ram_rdata;
      end else begin
         for (int k = 0; k < N_IN; k++)
            if (idx == IW'(k)) rd_data = port_in[k*DW +: DW];
      end
   end

   for (genvar k = 0; k < N_OUT; k++) begin : g_out
      logic          hit;
      logic [DW-1:0] data_q;
      logic          stb_q;
      assign hit = acc_valid && acc_wr && in_win && (idx == IW'(k));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            data_q <= '0;
            stb_q  <= 1'b0;
         end else begin
            stb_q <= hit;
            if (hit) data_q <= wr_data;
         end
      end
      assign port_out[k*DW +: DW] = data_q;
      assign port_out_stb[k]      = stb_q;
   end
endmodule

// File: rtl/agu_top.sv
module agu_top #(
   parameter int DW     = 16,
   parameter int NUM_AR = 6,
   parameter int SEL_W  = 3,
   parameter int DIR_W  = 12,
   parameter int N_IN   = 1,
   parameter int N_OUT  = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_valid,
   input  logic                acc_indirect,
   input  logic [DIR_W-1:0]    acc_dir,
   input  logic [SEL_W-1:0]    acc_sel,
   input  logic [1:0]          acc_mod,
   input  logic                acc_rd,
   input  logic                acc_wr,
   input  logic [DW-1:0]       wr_data,
   input  logic                ar_wr_en,
   input  logic [SEL_W-1:0]    ar_wr_sel,
   input  logic [DW-1:0]       ar_wr_data,
   input  logic                ar_ld_en,
   input  logic [SEL_W-1:0]    ar_ld_sel,
   input  logic [DW-1:0]       ram_rdata,
   input  logic [N_IN*DW-1:0]  port_in,
   output logic [DW-1:0]       ram_addr,
   output logic                ram_rd,
   output logic                ram_wr,
   output logic [DW-1:0]       ram_wdata,
   output logic [DW-1:0]       rd_data,
   output logic [N_IN-1:0]     port_in_sel,
   output logic [N_OUT*DW-1:0] port_out,
   output logic [N_OUT-1:0]    port_out_stb
);
   if (DW < DIR_W) begin : g_chk_dir
      $error("agu_top: DW must be at least DIR_W");
   end
   if (NUM_AR < 1 || NUM_AR > (1 << SEL_W)) begin : g_chk_sel
      $error("agu_top: NUM_AR must fit in SEL_W select bits");
   end
   if (N_IN < 1 || N_OUT < 1) begin : g_chk_ports
      $error("agu_top: at least one input and one output port");
   end

   logic [NUM_AR*DW-1:0] ar_flat;
   logic                 form_upd;
   logic [DW-1:0]        upd_val;

   agu_addr_form #(
      .DW(DW), .NUM_AR(NUM_AR), .SEL_W(SEL_W), .DIR_W(DIR_W)
   ) u_form (
      .ar_flat  (ar_flat),
      .indirect (acc_indirect),
      .sel      (acc_sel),
      .dir      (acc_dir),
      .mod      (acc_mod),
      .eff_addr (ram_addr),
      .upd_req  (form_upd),
      .upd_val  (upd_val)
   );

   agu_regbank #(
      .DW(DW), .NUM_AR(NUM_AR), .SEL_W(SEL_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd_en  (acc_valid && form_upd),
      .upd_sel (acc_sel),
      .upd_val (upd_val),
      .ld_en   (acc_valid && ar_ld_en),
      .ld_sel  (ar_ld_sel),
      .ld_val  (rd_data),
      .wr_en   (ar_wr_en),
      .wr_sel  (ar_wr_sel),
      .wr_val  (ar_wr_data),
      .ar_flat (ar_flat)
   );

   agu_io_window #(
      .DW(DW), .N_IN(N_IN), .N_OUT(N_OUT)
   ) u_io (
      .clk          (clk),
      .rst_n        (rst_n),
      .acc_valid    (acc_valid),
      .acc_rd       (acc_rd),
      .acc_wr       (acc_wr),
      .addr         (ram_addr),
      .wr_data      (wr_data),
      .ram_rdata    (ram_rdata),
      .port_in      (port_in),
      .ram_rd       (ram_rd),
      .ram_wr       (ram_wr),
      .rd_data      (rd_data),
      .port_in_sel  (port_in_sel),
      .port_out     (port_out),
      .port_out_stb (port_out_stb)
   );

   assign ram_wdata = wr_data;
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
   parameter int DW     = 16,
   parameter int SEL_W  = 3,
   parameter int DIR_W  = 12,
   parameter int N_IN   = 1,
   parameter int N_OUT  = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                acc_valid,
   input logic                acc_indirect,
   input logic [DIR_W-1:0]    acc_dir,
   input logic [SEL_W-1:0]    acc_sel,
   input logic [1:0]          acc_mod,
   input logic                acc_rd,
   input logic                acc_wr,
   input logic [DW-1:0]       wr_data,
   input logic                ar_wr_en,
   input logic [SEL_W-1:0]    ar_wr_sel,
   input logic                ar_ld_en,
   input logic [SEL_W-1:0]    ar_ld_sel,
   input logic [DW-1:0]       ram_addr,
   input logic                ram_rd,
   input logic                ram_wr,
   input logic [N_IN-1:0]     port_in_sel,
   input logic [N_OUT*DW-1:0] port_out,
   input logic [N_OUT-1:0]    port_out_stb
);
   localparam int NPORT = (N_IN > N_OUT) ? N_IN : N_OUT;
   localparam logic [DW-1:0] WIN_BASE = ~DW'(NPORT - 1);
   localparam logic [DW-1:0] TOP_ADDR = '1;

   logic top_write;
   logic inc_clean;
   assign top_write = acc_valid && acc_wr && ram_addr == TOP_ADDR;
   assign inc_clean = acc_valid && acc_indirect && acc_sel < SEL_W'(6) && acc_mod == 2'b01
                      && !(ar_wr_en && ar_wr_sel == acc_sel)
                      && !(ar_ld_en && ar_ld_sel == acc_sel);

   assert_ram_outside_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_rd || ram_wr) |-> ram_addr < WIN_BASE);

   assert_direct_zero_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_indirect) |-> ram_addr == DW'(acc_dir));

   assert_post_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      inc_clean |=> ((acc_valid && acc_indirect && acc_sel == $past(acc_sel))
                     |-> ram_addr == $past(ram_addr) + DW'(1)));

   assert_in_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|port_in_sel) |-> ($onehot0(port_in_sel) && acc_rd && !ram_rd));

   assert_stb_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(port_out_stb));

   assert_out_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
      top_write |=> (port_out_stb[0] && port_out[DW-1:0] == $past(wr_data)));

   assert_stb_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (port_out_stb[0] && !top_write) |=> !port_out_stb[0]);

   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (!ram_rd && !ram_wr && port_in_sel == '0));
endmodule

bind agu_top agu_checker #(
   .DW(DW), .SEL_W(SEL_W), .DIR_W(DIR_W), .N_IN(N_IN), .N_OUT(N_OUT)
) u_agu_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .acc_valid    (acc_valid),
   .acc_indirect (acc_indirect),
   .acc_dir      (acc_dir),
   .acc_sel      (acc_sel),
   .acc_mod      (acc_mod),
   .acc_rd       (acc_rd),
   .acc_wr       (acc_wr),
   .wr_data      (wr_data),
   .ar_wr_en     (ar_wr_en),
   .ar_wr_sel    (ar_wr_sel),
   .ar_ld_en     (ar_ld_en),
   .ar_ld_sel    (ar_ld_sel),
   .ram_addr     (ram_addr),
   .ram_rd       (ram_rd),
   .ram_wr       (ram_wr),
   .port_in_sel  (port_in_sel),
   .port_out     (port_out),
   .port_out_stb (port_out_stb)
);

// File: tb/agu_top_bench.sv
module agu_top_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int N_IN = 2;
   localparam int N_OUT = 3;

   logic clk = 0;
   logic rst_n = 0;
   logic acc_valid = 0, acc_indirect = 0, acc_rd = 0, acc_wr = 0;
   logic [11:0] acc_dir = '0;
   logic [2:0]  acc_sel = '0;
   logic [1:0]  acc_mod = '0;
   logic [15:0] wr_data = '0;
   logic ar_wr_en = 0, ar_ld_en = 0;
   logic [2:0]  ar_wr_sel = '0, ar_ld_sel = '0;
   logic [15:0] ar_wr_data = '0;
   logic [15:0] ram_rdata;
   logic [N_IN*DW-1:0] port_in;
   logic [15:0] ram_addr, ram_wdata, rd_data;
   logic ram_rd, ram_wr;
   logic [N_IN-1:0] port_in_sel;
   logic [N_OUT*DW-1:0] port_out;
   logic [N_OUT-1:0] port_out_stb;

   logic [15:0] mem [256];
   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign ram_rdata = mem[ram_addr[7:0]];
   assign port_in   = {16'hBEEF, 16'h1234};

   agu_top #(.N_IN(N_IN), .N_OUT(N_OUT)) u_agu_top (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_indirect(acc_indirect),
      .acc_dir(acc_dir), .acc_sel(acc_sel), .acc_mod(acc_mod), .acc_rd(acc_rd),
      .acc_wr(acc_wr), .wr_data(wr_data), .ar_wr_en(ar_wr_en), .ar_wr_sel(ar_wr_sel),
      .ar_wr_data(ar_wr_data), .ar_ld_en(ar_ld_en), .ar_ld_sel(ar_ld_sel),
      .ram_rdata(ram_rdata), .port_in(port_in), .ram_addr(ram_addr), .ram_rd(ram_rd),
      .ram_wr(ram_wr), .ram_wdata(ram_wdata), .rd_data(rd_data),
      .port_in_sel(port_in_sel), .port_out(port_out), .port_out_stb(port_out_stb));

   task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic ind, input logic [2:0] sel,
                        input logic [11:0] dir, input logic [1:0] md,
                        input logic rd, input logic wr, input logic [15:0] wd,
                        input logic we, input logic [2:0] wsel, input logic [15:0] wval,
                        input logic le, input logic [2:0] lsel);
      @(negedge clk);
      acc_valid = v; acc_indirect = ind; acc_sel = sel; acc_dir = dir; acc_mod = md;
      acc_rd = rd; acc_wr = wr; wr_data = wd;
      ar_wr_en = we; ar_wr_sel = wsel; ar_wr_data = wval;
      ar_ld_en = le; ar_ld_sel = lsel;
      #1;
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic idle();
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic set_ar(input logic [2:0] s, input logic [15:0] v);
      drive(0, 0, 0, 0, 0, 0, 0, 0, 1, s, v, 0, 0);
      tick();
   endtask

   task automatic rd_ind(input logic [2:0] s, input logic [1:0] md);
      drive(1, 1, s, 0, md, 1, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_reset();
      rd_ind(3, 0);
      check("R1 ar3 reset", ram_addr, 16'h0000);
      check("R1 port_out reset", port_out, '0);
      check("R1 strobes reset", {port_out_stb, port_in_sel}, '0);
      tick();
   endtask

   task automatic t_direct();
      drive(1, 0, 2, 12'hABC, 2'b01, 1, 0, 0, 0, 0, 0, 0, 0);
      check("R2 direct addr", ram_addr, 16'h0ABC);
      check("R11 direct ram_rd", ram_rd, 1);
      check("R11 direct rd_data", rd_data, 16'hA5BC);
      tick();
      rd_ind(2, 0);
      check("R2 ar2 unchanged", ram_addr, 16'h0000);
      tick();
   endtask

   task automatic t_postmod();
      set_ar(2, 16'h0010);
      rd_ind(2, 2'b01);
      check("R5 written value used", ram_addr, 16'h0010);
      tick();
      rd_ind(2, 2'b10);
      check("R4 post-increment", ram_addr, 16'h0011);
      tick();
      rd_ind(2, 2'b11);
      check("R4 post-decrement", ram_addr, 16'h0010);
      tick();
      rd_ind(2, 2'b00);
      check("R4 code 11 holds", ram_addr, 16'h0010);
      tick();
   endtask

   task automatic t_wrap();
      set_ar(4, 16'h0000);
      rd_ind(4, 2'b10);
      tick();
      rd_ind(4, 2'b00);
      check("R4 decrement wraps", ram_addr, 16'hFFFF);
      check("R8 no ram_rd in window", ram_rd, 0);
      check("R9 port0 select", port_in_sel, 2'b01);
      check("R9 port0 data", rd_data, 16'h1234);
      tick();
      drive(1, 1, 4, 0, 2'b01, 0, 0, 0, 0, 0, 0, 0, 0);
      tick();
      rd_ind(4, 0);
      check("R4 increment wraps", ram_addr, 16'h0000);
      tick();
   endtask

   task automatic t_load();
      set_ar(1, 16'h0020);
      drive(1, 1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 1, 5);
      check("R6 load source data", rd_data, 16'h0055);
      tick();
      rd_ind(5, 0);
      check("R6 loaded register", ram_addr, 16'h0055);
      tick();
   endtask

   task automatic t_priority();
      set_ar(3, 16'h0030);
      drive(1, 1, 3, 0, 2'b01, 1, 0, 0, 0, 0, 0, 1, 3);
      tick();
      rd_ind(3, 0);
      check("R7 load beats post-mod", ram_addr, 16'hA530);
      tick();
      drive(1, 1, 1, 0, 0, 1, 0, 0, 1, 5, 16'h0077, 1, 5);
      tick();
      rd_ind(5, 0);
      check("R7 write beats load", ram_addr, 16'h0077);
      tick();
   endtask

   task automatic t_bad_sel();
      set_ar(0, 16'h0040);
      rd_ind(6, 2'b01);
      check("R3 select 6 gives 0", ram_addr, 16'h0000);
      tick();
      rd_ind(7, 2'b10);
      check("R3 select 7 gives 0", ram_addr, 16'h0000);
      tick();
      rd_ind(0, 0);
      check("R3 ar0 untouched", ram_addr, 16'h0040);
      tick();
   endtask

   task automatic t_port_in();
      set_ar(0, 16'hFFFE);
      rd_ind(0, 0);
      check("R9 port1 select", port_in_sel, 2'b10);
      check("R9 port1 data", rd_data, 16'hBEEF);
      check("R8 port1 no ram_rd", ram_rd, 0);
      tick();
      set_ar(0, 16'hFFFD);
      rd_ind(0, 0);
      check("R9 empty slot select", port_in_sel, 2'b00);
      check("R9 empty slot data", rd_data, 16'h0000);
      check("R8 empty slot no ram_rd", ram_rd, 0);
      tick();
   endtask

   task automatic t_port_out();
      drive(1, 1, 0, 0, 0, 0, 1, 16'hC0DE, 0, 0, 0, 0, 0);
      check("R8 port write no ram_wr", ram_wr, 0);
      check("R10 no strobe yet", port_out_stb, 3'b000);
      tick();
      check("R10 strobe port2", port_out_stb, 3'b100);
      check("R10 data port2", port_out[47:32], 16'hC0DE);
      idle();
      tick();
      check("R10 strobe one cycle", port_out_stb, 3'b000);
      check("R10 data held", port_out[47:32], 16'hC0DE);
      set_ar(0, 16'h0040);
      drive(1, 1, 0, 0, 0, 0, 1, 16'h5A5A, 0, 0, 0, 0, 0);
      check("R11 ram_wr outside window", ram_wr, 1);
      check("R11 ram_wdata", ram_wdata, 16'h5A5A);
      tick();
      check("R11 no port strobe", port_out_stb, 3'b000);
   endtask

   task automatic t_invalid();
      set_ar(0, 16'hFFFF);
      drive(0, 1, 0, 0, 2'b01, 1, 1, 16'h9999, 0, 0, 0, 1, 2);
      check("R12 no strobes", {ram_rd, ram_wr, port_in_sel}, '0);
      tick();
      check("R12 no port strobe", port_out_stb, 3'b000);
      check("R12 port0 untouched", port_out[15:0], 16'h0000);
      rd_ind(0, 0);
      check("R12 no post-mod", ram_addr, 16'hFFFF);
      tick();
      rd_ind(2, 0);
      check("R12 no load", ram_addr, 16'h0010);
      tick();
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 20000);
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 16'hA500 + 16'(i);
      mem[8'h20] = 16'h0055;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      t_reset();
      t_direct();
      t_postmod();
      t_wrap();
      t_load();
      t_priority();
      t_bad_sel();
      t_port_in();
      t_port_out();
      t_invalid();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule